// File: doc/BRIEF.md
# Nibble-Serial Video Memory Read Port

This block connects several internal read requesters to an external read-only word memory through four address pins and four data pins. A 16-bit word address is sent one nibble per clock, so one serial cycle of four clocks carries exactly one read. Serial cycles follow each other with no gap. The data word returns on the data pins in the same nibble order after a fixed latency. The block reassembles the word and hands it, with a one-clock valid pulse, to the requester that issued it.

Three requesters compete for each serial cycle under a fixed priority: the tile fetcher first, then the display coprocessor, then the sprite fetcher. If nobody asks, a read of address 0 is sent and its data is dropped. A tag pipeline carries the identity of each granted requester alongside the outstanding read until the word is complete.

The memory side has no clock-phase signal, so the block provides two aids. While it is held in reset or disabled, the address pins echo the data pins two clocks later, which lets the memory side measure the round-trip delay. On start-up, the block sends a fixed synchronisation word whose nibbles are one-hot and rise in order, so the memory side can find where serial cycles begin.

The controller has three states:
- ST_LOOP: loopback echo.
- ST_SYNC: one clock with address pins at zero, during which the synchronisation word is loaded.
- ST_RUN: normal reads.

The transitions are:
- ST_LOOP→ST_SYNC when rst_n and fetch_en are both high.
- ST_SYNC→ST_RUN unconditionally.
- ST_RUN→ST_RUN while enabled.
- Any state→ST_LOOP whenever rst_n or fetch_en is low.

Top module: `nibble_read_port`

## Requirements
- R1: While rst_n is low, gnt stays all zero, and rsp_valid is all zero from the second clock of reset onward.
- R2: A granted address is driven on addr_nib one nibble per clock, starting with bits 3..0 in the clock after the grant and ending with bits 15..12 three clocks later. Serial cycles of four clocks follow back to back.
- R3: The nibbles of a read's data are sampled from data_nib in ascending order. Nibble 0 is sampled LAT clocks after the clock in which address nibble 0 is on addr_nib. The word appears on rsp_data with a one-clock rsp_valid pulse LAT+4 clocks after address nibble 0.
- R4: A grant is a one-clock one-hot pulse on gnt, given only in the last clock of a serial cycle. Bit 0 (tile) beats bit 1 (coprocessor), and bit 1 beats bit 2 (sprite).
- R5: Several reads may be outstanding at once. Each returned word is flagged only on the rsp_valid bit of the requester whose grant produced it.
- R6: After rst_n rises, or after fetch_en rises while out of reset, addr_nib shows 0 for one clock and then 1, 2, 4, 8 (word 0x8421). No grant is given before the last of these clocks, and the data of that read is never delivered.
- R7: While rst_n or fetch_en is low, addr_nib equals the value of data_nib two clocks earlier.
- R8: In a serial cycle with no request, address 0 is sent as four zero nibbles and no rsp_valid pulse results from it.
- R9: Dropping fetch_en cancels all outstanding reads: from the next clock, rsp_valid stays zero until new reads complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_en | input | 1 | Enables reading; low selects loopback |
| req | input | NREQ | Request per requester, bit 0 highest priority |
| req_addr | input | NREQ*16 | Word address per requester, requester i in bits 16i+15..16i |
| gnt | output | NREQ | One-hot grant pulse |
| rsp_valid | output | NREQ | One-clock pulse on the bit of the requester owning rsp_data |
| rsp_data | output | 16 | Returned data word |
| addr_nib | output | 4 | Serial address nibble to memory |
| data_nib | input | 4 | Serial data nibble from memory |

## Verification
The following are checked on every clock by properties:
- gnt is one-hot and follows the priority order.
- A grant's low nibble appears on the pins one clock later.
- rsp_valid never flags two requesters at once.
- The synchronisation word begins right after ST_SYNC.
- The loopback echo holds whenever the port was disabled.
- The tag pipeline drains when cleared.

Only the bench's scenarios can show the following:
- Complete words come back intact to the right requester after the exact latency.
- Dummy and synchronisation reads stay silent.
- Cancelled reads never surface.
- A memory model that locks onto the synchronisation word stays aligned with the block.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
    // controller states
    typedef enum logic [1:0] {
        ST_LOOP = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } nrp_state_t;
endpackage

// File: rtl/nrp_arbiter.sv
// Fixed-priority grant: lowest index wins; grant only when en_i is high.
module nrp_arbiter #(
    parameter int NREQ = 3,
    parameter int AW   = 16
) (
    input  logic               en_i,
    input  logic [NREQ-1:0]    req_i,
    input  logic [NREQ*AW-1:0] addr_i,
    output logic [NREQ-1:0]    gnt_o,
    output logic [AW-1:0]      addr_o
);
    logic [AW-1:0] acc [NREQ+1];

    assign acc[0] = '0;

    for (genvar gi = 0; gi < NREQ; gi++) begin : g_lane
        if (gi == 0) begin : g_top
            assign gnt_o[gi] = en_i & req_i[gi];
        end else begin : g_low
            assign gnt_o[gi] = en_i & req_i[gi] & ~(|req_i[gi-1:0]);
        end
        assign acc[gi+1] = acc[gi] | (gnt_o[gi] ? addr_i[gi*AW +: AW] : '0);
    end

    // no grant -> address 0 (dummy read)
    assign addr_o = acc[NREQ];
endmodule

// File: rtl/nrp_tag_pipe.sv
// Shift line of requester tags, one stage per clock, cleared on cancel.
module nrp_tag_pipe #(
    parameter int W     = 3,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] tag_i,
    output logic [W-1:0] tag_o
);
    logic [W-1:0] stg [DEPTH];

    for (genvar gs = 0; gs < DEPTH; gs++) begin : g_stage
        always_ff @(posedge clk) begin
            if (clr_i) begin
                stg[gs] <= '0;
            end else if (gs == 0) begin
                stg[gs] <= tag_i;
            end else begin
                stg[gs] <= stg[(gs == 0) ? 0 : gs-1];
            end
        end
    end

    assign tag_o = stg[DEPTH-1];

    // R9: a cancel empties the line, nothing emerges next clock
    a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (tag_o == '0));
endmodule

// File: rtl/nibble_read_port.sv
module nibble_read_port
    import nrp_pkg::*;
#(
    parameter int NREQ  = 3,
    parameter int NIB_W = 4,
    parameter int NIBS  = 4,
    parameter int LAT   = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fetch_en,
    input  logic [NREQ-1:0]           req,
    input  logic [NREQ*NIB_W*NIBS-1:0] req_addr,
    output logic [NREQ-1:0]           gnt,
    output logic [NREQ-1:0]           rsp_valid,
    output logic [NIB_W*NIBS-1:0]     rsp_data,
    output logic [NIB_W-1:0]          addr_nib,
    input  logic [NIB_W-1:0]          data_nib
);
    localparam int WORD_W = NIB_W * NIBS;
    localparam int REST_W = WORD_W - NIB_W;
    localparam int PH_W   = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(NIBS - 1);
    localparam int DEPTH  = LAT + NIBS;

    // nibble k of the start-up word is one-hot, rising with k
    function automatic logic [WORD_W-1:0] sync_pattern();
        logic [WORD_W-1:0] r;
        r = '0;
        for (int k = 0; k < NIBS; k++) begin
            r[k*NIB_W +: NIB_W] = NIB_W'(1 << (k % NIB_W));
        end
        return r;
    endfunction
    localparam logic [WORD_W-1:0] SYNC_WORD = sync_pattern();

    nrp_state_t        state_q, nxt;
    logic [PH_W-1:0]   ph_q;
    logic [NIB_W-1:0]  addr_q, echo_q;
    logic [REST_W-1:0] sh_q, dat_q;
    logic [WORD_W-1:0] sel_addr, ld_word;
    logic [NREQ-1:0]   tag_out, rsp_q;
    logic [WORD_W-1:0] rsp_d_q;
    logic              arb_en, flush;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        state_q <= nxt;
    end

    always_comb begin
        nxt = state_q;
        if (!rst_n || !fetch_en) begin
            nxt = ST_LOOP;
        end else begin
            unique case (state_q)
                ST_LOOP: nxt = ST_SYNC;
                ST_SYNC: nxt = ST_RUN;
                ST_RUN:  nxt = ST_RUN;
                default: nxt = ST_LOOP;
            endcase
        end
    end

    assign flush  = (nxt == ST_LOOP);
    assign arb_en = (state_q == ST_RUN) && (nxt == ST_RUN) && (ph_q == LAST);
    assign ld_word = (state_q == ST_SYNC) ? SYNC_WORD : sel_addr;

    nrp_arbiter #(.NREQ(NREQ), .AW(WORD_W)) u_arb (
        .en_i   (arb_en),
        .req_i  (req),
        .addr_i (req_addr),
        .gnt_o  (gnt),
        .addr_o (sel_addr)
    );

    nrp_tag_pipe #(.W(NREQ), .DEPTH(DEPTH)) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (flush),
        .tag_i (gnt),
        .tag_o (tag_out)
    );

    // ---------------- datapath / outputs ----------------
    always_ff @(posedge clk) begin
        echo_q  <= data_nib;
        dat_q   <= {data_nib, dat_q[REST_W-1:NIB_W]};
        rsp_d_q <= {data_nib, dat_q};
        if (flush) begin
            addr_q <= echo_q;
            ph_q   <= LAST;
            sh_q   <= '0;
            rsp_q  <= '0;
        end else begin
            rsp_q <= tag_out;
            unique case (state_q)
                ST_LOOP: begin
                    addr_q <= '0;
                    ph_q   <= LAST;
                    sh_q   <= '0;
                end
                ST_SYNC, ST_RUN: begin
                    ph_q <= (ph_q == LAST) ? '0 : ph_q + PH_W'(1);
                    if (ph_q == LAST) begin
                        addr_q <= ld_word[NIB_W-1:0];
                        sh_q   <= ld_word[WORD_W-1:NIB_W];
                    end else begin
                        addr_q <= sh_q[NIB_W-1:0];
                        sh_q   <= sh_q >> NIB_W;
                    end
                end
                default: begin
                    addr_q <= '0;
                    ph_q   <= LAST;
                    sh_q   <= '0;
                end
            endcase
        end
    end

    assign addr_nib  = addr_q;
    assign rsp_valid = rsp_q;
    assign rsp_data  = rsp_d_q;

    // ---------------- assertions ----------------
    a_r4_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    for (genvar ga = 1; ga < NREQ; ga++) begin : g_prio_chk
        a_r4_priority: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[ga] |-> !(|req[ga-1:0]));
    end

    a_r2_first_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> (addr_nib == $past(sel_addr[NIB_W-1:0])));

    a_r5_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    a_r6_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC && nxt == ST_RUN) |=> (addr_nib == SYNC_WORD[NIB_W-1:0]));

    a_r7_echo: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && !$past(fetch_en)) |-> (addr_nib == $past(data_nib, 2)));
endmodule

// File: tb/sim_nibble_read_port.sv
module sim_nibble_read_port;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ = 3;
    localparam int LAT  = 12;
    localparam int N    = 256;

    logic        clk, rst_n, fetch_en;
    logic [2:0]  req;
    logic [47:0] req_addr;
    logic [2:0]  gnt, rsp_valid;
    logic [15:0] rsp_data;
    logic [3:0]  addr_nib, data_nib;

    nibble_read_port #(.NREQ(NREQ), .NIB_W(4), .NIBS(4), .LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .req(req), .req_addr(req_addr),
        .gnt(gnt), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .addr_nib(addr_nib), .data_nib(data_nib)
    );

    // {req bits (sprite,cop,tile), expected one-hot grant}
    localparam logic [5:0] TBL [8] = '{
        6'b111_001, 6'b110_010, 6'b100_100, 6'b101_001,
        6'b010_010, 6'b011_001, 6'b000_000, 6'b100_100
    };

    int total = 0, bad = 0, cyc = 0;
    bit done = 0, lb_mode = 1, locked = 0;
    int ph_b = 0;
    logic [15:0] last4 = '0, w = '0;
    logic [3:0]  dsched [N];
    logic [3:0]  dh [N];
    logic [2:0]  exp_v [N];
    logic [15:0] exp_d [N];

    function automatic logic [15:0] mem_f(input logic [15:0] a);
        return a ^ 16'hC35A ^ {a[7:0], a[15:8]};
    endfunction

    function automatic logic [15:0] addr_of(input int k, input int i);
        return 16'(16'h1357 * (k + 1) + i * 16'h0F0F);
    endfunction

    initial clk = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        for (int i = 0; i < N; i++) begin
            dsched[i] = '0; dh[i] = '0; exp_v[i] = '0; exp_d[i] = '0;
        end
    end

    // memory model and response monitor
    always @(negedge clk) begin
        logic [15:0] d;
        int c;
        cyc = cyc + 1;
        c = cyc % N;
        data_nib = lb_mode ? 4'((cyc * 7 + 3) & 15) : dsched[c];
        dsched[c] = '0;
        dh[c] = data_nib;
        last4 = {last4[11:0], addr_nib};
        if (lb_mode) begin
            locked = 0;
        end else if (!locked) begin
            if (last4 == 16'h1248) begin
                locked = 1;
                ph_b = 3;
            end
        end else begin
            ph_b = (ph_b + 1) % 4;
            w[ph_b*4 +: 4] = addr_nib;
            if (ph_b == 3) begin
                d = mem_f(w);
                for (int i = 0; i < 4; i++) dsched[(cyc - 3 + LAT + i) % N] = d[i*4 +: 4];
            end
        end
        if (exp_v[c] != 0 || rsp_valid != 0) begin
            total++;
            if (rsp_valid !== exp_v[c] || (exp_v[c] != 0 && rsp_data !== exp_d[c])) begin
                bad++;
                $display("FAIL R3/R5 response cyc=%0d valid=%b data=%h exp valid=%b data=%h",
                         cyc, rsp_valid, rsp_data, exp_v[c], exp_d[c]);
            end
        end
        exp_v[c] = '0;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic sync_check();
        step(); chk("R6 idle zero", 16'(addr_nib), 16'h0);
        step(); chk("R6 sync n0", 16'(addr_nib), 16'h1); chk("R6 no early grant", 16'(gnt), 16'h0);
        step(); chk("R6 sync n1", 16'(addr_nib), 16'h2);
        step(); chk("R6 sync n2", 16'(addr_nib), 16'h4);
        step(); chk("R6 sync n3", 16'(addr_nib), 16'h8);
    endtask

    // called in the last clock of a serial cycle; leaves in the next one
    task automatic grant(input logic [2:0] rv, input logic [2:0] eg, input int k);
        int idx;
        req = rv;
        req_addr = {addr_of(k, 2), addr_of(k, 1), addr_of(k, 0)};
        #1;
        chk("R4 grant", 16'(gnt), 16'(eg));
        if (eg != 0) begin
            idx = eg[0] ? 0 : (eg[1] ? 1 : 2);
            exp_v[(cyc + LAT + 5) % N] = eg;
            exp_d[(cyc + LAT + 5) % N] = mem_f(addr_of(k, idx));
        end
        repeat (4) step();
    endtask

    initial begin
        rst_n = 0; fetch_en = 1; req = '0; req_addr = '0;
        repeat (3) step();
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R7 echo in reset", 16'(addr_nib), 16'(dh[(cyc - 2) % N]));
            chk("R1 gnt in reset", 16'(gnt), 16'h0);
            chk("R1 rsp in reset", 16'(rsp_valid), 16'h0);
        end
        rst_n = 1; lb_mode = 0;
        sync_check();

        // table walk: priority and back-to-back returns (R4, R5, R3)
        for (int k = 0; k < 8; k++) grant(TBL[k][5:3], TBL[k][2:0], k);

        // R2: nibble order of one known address
        req = 3'b001; req_addr = {32'h0, 16'h3C9D};
        #1;
        chk("R2 grant", 16'(gnt), 16'h1);
        exp_v[(cyc + LAT + 5) % N] = 3'b001;
        exp_d[(cyc + LAT + 5) % N] = mem_f(16'h3C9D);
        step(); req = '0; chk("R2 nibble0", 16'(addr_nib), 16'hD);
        step(); chk("R2 nibble1", 16'(addr_nib), 16'h9);
        step(); chk("R2 nibble2", 16'(addr_nib), 16'hC);
        step(); chk("R2 nibble3", 16'(addr_nib), 16'h3);

        // R8: idle serial cycle sends address 0
        req = '0; #1;
        chk("R8 no grant", 16'(gnt), 16'h0);
        for (int i = 0; i < 4; i++) begin
            step(); chk("R8 dummy nibble", 16'(addr_nib), 16'h0);
        end
        repeat (LAT + 8) step();

        // R9: cancel with reads outstanding
        grant(3'b001, 3'b001, 10);
        req = 3'b010; #1;
        chk("R9 grant before cancel", 16'(gnt), 16'h2);
        step(); step();
        fetch_en = 0; req = '0; lb_mode = 1;
        for (int i = 0; i < N; i++) exp_v[i] = '0;
        step(); step();
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R7 echo when disabled", 16'(addr_nib), 16'(dh[(cyc - 2) % N]));
        end
        for (int i = 0; i < LAT + 6; i++) begin
            step(); chk("R9 no stale response", 16'(rsp_valid), 16'h0);
        end

        // re-enable: sync again, then a normal read
        fetch_en = 1; lb_mode = 0;
        sync_check();
        grant(3'b100, 3'b100, 11);
        req = '0;
        repeat (LAT + 10) step();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule